// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two word-aligned stack pointers, one for the main stack and one for the process stack. It presents a single architectural stack-pointer name that resolves to one of them. The resolution depends on the processor mode and on a stack-select control bit. Ordinary thread code may run on either stack. Exception handlers always run on the main stack. The block tracks the mode itself from exception entry and exit strobes.

On exception entry the block records the stack choice that was in force before entry as a return marker, for the link register. On exception return it decodes a marker supplied by the core and restores the matching mode and stack. Register-file read and write ports address the pointers by a two-bit select code. The code names either the stack-pointer alias or one of the two pointers directly. The block does not do register stacking to memory, does not check privilege, and holds no other register-file state.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset the alias resolves to the main pointer, the main pointer holds the parameter MSP_RST, the process pointer holds PSP_RST, the active-stack output is 0 and the marker output is 0.
- R2: Select code 0 is the alias. A read returns the active pointer. A write updates the pointer that was active in the cycle of the write, even when an exception entry happens in that same cycle. The sp_o output always equals the active pointer.
- R3: Select code 1 reads or writes the main pointer and select code 2 reads or writes the process pointer. Neither depends on which pointer the alias resolves to, and a direct write leaves the other pointer unchanged.
- R4: Every pointer write forces bits [1:0] to zero.
- R5: In thread mode, a control write of 1 selects the process stack and a control write of 0 selects the main stack. The new choice shows on the active-stack output in the cycle after the write.
- R6: An entry strobe switches to handler mode on the main stack and clears the stack-select bit. It also loads the marker with the state in force before entry: 0xFFFFFFF9 for thread on main, 0xFFFFFFFD for thread on process, and 0xFFFFFFF1 for handler.
- R7: In handler mode, control writes are discarded and the main stack stays active.
- R8: An exit strobe in handler mode decodes the return value. 0xFFFFFFF9 gives thread mode on main, 0xFFFFFFFD gives thread mode on process, and 0xFFFFFFF1 stays in handler mode on main.
- R9: An exit strobe carrying any other value, or arriving in thread mode, changes no state.
- R10: When entry and exit strobes arrive in the same cycle, the entry is taken and the exit is dropped.
- R11: Select code 3 reads as zero, and a write with select code 3 changes neither pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | 2 | Read select: 0 alias, 1 main, 2 process, 3 none |
| rd_data | output | 32 | Read data for rd_sel |
| wr_en | input | 1 | Pointer write strobe |
| wr_sel | input | 2 | Write select, same coding as rd_sel |
| wr_data | input | 32 | Pointer write data |
| ctrl_wr_en | input | 1 | Stack-select bit write strobe |
| ctrl_wr_spsel | input | 1 | Stack-select bit value |
| exc_entry | input | 1 | Exception entry strobe |
| exc_exit | input | 1 | Exception return strobe |
| exc_ret_val | input | 32 | Return marker presented with exc_exit |
| sp_o | output | 32 | Current value of the alias |
| active_psp | output | 1 | 1 when the alias resolves to the process pointer |
| lr_marker | output | 32 | Marker captured on the last entry |

## Verification
The bench builds the unit with a 32-bit data width and 2 alignment bits. It sets the main reset value to 0x20001000 and the process reset value to 0. Because the main reset value differs from the default, the reset check shows that the parameter reaches the register. Because the process reset value is zero, any stray write to that pointer is visible. With a 32-bit width the marker constants take their full-width form, so nested entry from handler mode, return into handler mode and rejected return values can all be driven with exact patterns.

// File: rtl/spbank_pkg.sv
package spbank_pkg;

    typedef enum logic [1:0] {
        SEL_ALIAS = 2'd0,
        SEL_MAIN  = 2'd1,
        SEL_PROC  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam logic [3:0] MK_NIB_HANDLER   = 4'h1;
    localparam logic [3:0] MK_NIB_THR_MAIN  = 4'h9;
    localparam logic [3:0] MK_NIB_THR_PROC  = 4'hD;

endpackage

// File: rtl/spbank_marker_codec.sv
module spbank_marker_codec #(
    parameter int DATA_W = 32
) (
    input  logic              handler_i,
    input  logic              spsel_i,
    input  logic [DATA_W-1:0] ret_val_i,
    output logic [DATA_W-1:0] marker_o,
    output logic              ret_ok_o,
    output logic              ret_handler_o,
    output logic              ret_psp_o
);
    import spbank_pkg::*;

    localparam int HI_W = DATA_W - 4;
    localparam logic [DATA_W-1:0] MK_HANDLER  = {{HI_W{1'b1}}, MK_NIB_HANDLER};
    localparam logic [DATA_W-1:0] MK_THR_MAIN = {{HI_W{1'b1}}, MK_NIB_THR_MAIN};
    localparam logic [DATA_W-1:0] MK_THR_PROC = {{HI_W{1'b1}}, MK_NIB_THR_PROC};

    // Encode the state in force before entry.
    always_comb begin
        if (handler_i)    marker_o = MK_HANDLER;
        else if (spsel_i) marker_o = MK_THR_PROC;
        else              marker_o = MK_THR_MAIN;
    end

    // Decode a return value.
    always_comb begin
        ret_ok_o      = 1'b0;
        ret_handler_o = 1'b0;
        ret_psp_o     = 1'b0;
        if (ret_val_i == MK_HANDLER) begin
            ret_ok_o      = 1'b1;
            ret_handler_o = 1'b1;
        end else if (ret_val_i == MK_THR_MAIN) begin
            ret_ok_o      = 1'b1;
        end else if (ret_val_i == MK_THR_PROC) begin
            ret_ok_o      = 1'b1;
            ret_psp_o     = 1'b1;
        end
    end

endmodule

// File: rtl/spbank_mode_ctrl.sv
module spbank_mode_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_entry_i,
    input  logic              exc_exit_i,
    input  logic [DATA_W-1:0] exc_ret_val_i,
    input  logic              ctrl_wr_en_i,
    input  logic              ctrl_wr_spsel_i,
    output logic              use_psp_o,
    output logic [DATA_W-1:0] marker_o
);

    typedef struct packed {
        logic              handler;
        logic              spsel;
        logic [DATA_W-1:0] marker;
    } mode_st_t;

    mode_st_t st_d, st_q;

    logic [DATA_W-1:0] enc_marker;
    logic              ret_ok, ret_handler, ret_psp;

    spbank_marker_codec #(.DATA_W(DATA_W)) u_codec (
        .handler_i     (st_q.handler),
        .spsel_i       (st_q.spsel),
        .ret_val_i     (exc_ret_val_i),
        .marker_o      (enc_marker),
        .ret_ok_o      (ret_ok),
        .ret_handler_o (ret_handler),
        .ret_psp_o     (ret_psp)
    );

    // Priority: entry, then a valid return in handler mode, then a thread-mode control write.
    always_comb begin
        st_d = st_q;
        if (exc_entry_i) begin
            st_d.marker  = enc_marker;
            st_d.handler = 1'b1;
            st_d.spsel   = 1'b0;
        end else if (exc_exit_i && st_q.handler && ret_ok) begin
            st_d.handler = ret_handler;
            st_d.spsel   = ret_psp;
        end else if (ctrl_wr_en_i && !st_q.handler) begin
            st_d.spsel   = ctrl_wr_spsel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign use_psp_o = !st_q.handler && st_q.spsel;
    assign marker_o  = st_q.marker;

    // R6: entry lands in handler mode with the select bit cleared.
    a_r6_entry_handler: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry_i |=> (st_q.handler && !st_q.spsel));

    // R7: the select bit never survives into handler mode.
    a_r7_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.handler |-> !st_q.spsel);

    // R10: a simultaneous exit cannot leave handler mode.
    a_r10_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry_i && exc_exit_i) |=> st_q.handler);

    // R9: an exit in thread mode leaves the mode and the select bit alone.
    a_r9_thread_exit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.handler && exc_exit_i && !exc_entry_i && !ctrl_wr_en_i)
        |=> (!st_q.handler && st_q.spsel == $past(st_q.spsel)));

    // R6: the marker moves only on entry.
    a_r6_marker_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_entry_i |=> $stable(st_q.marker));

endmodule

// File: rtl/spbank_ptr_file.sv
module spbank_ptr_file #(
    parameter int                DATA_W  = 32,
    parameter int                ALIGN_W = 2,
    parameter logic [DATA_W-1:0] MSP_RST = 32'h2000_4000,
    parameter logic [DATA_W-1:0] PSP_RST = 32'h0000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  spbank_pkg::reg_sel_e  wr_sel_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  use_psp_i,
    output logic [DATA_W-1:0]     msp_o,
    output logic [DATA_W-1:0]     psp_o
);
    import spbank_pkg::*;

    localparam logic [DATA_W-1:0] ALIGN_MASK = ~{{(DATA_W-ALIGN_W){1'b0}}, {ALIGN_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] msp;
        logic [DATA_W-1:0] psp;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic [DATA_W-1:0] wr_aligned;

    assign wr_aligned = wr_data_i & ALIGN_MASK;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_ALIAS: begin
                    if (use_psp_i) st_d.psp = wr_aligned;
                    else           st_d.msp = wr_aligned;
                end
                SEL_MAIN: st_d.msp = wr_aligned;
                SEL_PROC: st_d.psp = wr_aligned;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.msp <= MSP_RST & ALIGN_MASK;
            st_q.psp <= PSP_RST & ALIGN_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign msp_o = st_q.msp;
    assign psp_o = st_q.psp;

    // R4: both pointers stay aligned.
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.msp[ALIGN_W-1:0] == '0) && (st_q.psp[ALIGN_W-1:0] == '0));

    // R3: a direct main write leaves the process pointer unchanged.
    a_r3_main_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_MAIN) |=> (st_q.psp == $past(st_q.psp)));

    // R11: a write with the unused code changes neither pointer.
    a_r11_none_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_NONE) |=> ($stable(st_q.msp) && $stable(st_q.psp)));

endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit #(
    parameter int                DATA_W  = 32,
    parameter int                ALIGN_W = 2,
    parameter logic [DATA_W-1:0] MSP_RST = 32'h2000_4000,
    parameter logic [DATA_W-1:0] PSP_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctrl_wr_en,
    input  logic              ctrl_wr_spsel,
    input  logic              exc_entry,
    input  logic              exc_exit,
    input  logic [DATA_W-1:0] exc_ret_val,
    output logic [DATA_W-1:0] sp_o,
    output logic              active_psp,
    output logic [DATA_W-1:0] lr_marker
);
    import spbank_pkg::*;

    logic              use_psp;
    logic [DATA_W-1:0] msp, psp;
    reg_sel_e          rd_code, wr_code;

    assign rd_code = reg_sel_e'(rd_sel);
    assign wr_code = reg_sel_e'(wr_sel);

    spbank_mode_ctrl #(.DATA_W(DATA_W)) u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .exc_entry_i     (exc_entry),
        .exc_exit_i      (exc_exit),
        .exc_ret_val_i   (exc_ret_val),
        .ctrl_wr_en_i    (ctrl_wr_en),
        .ctrl_wr_spsel_i (ctrl_wr_spsel),
        .use_psp_o       (use_psp),
        .marker_o        (lr_marker)
    );

    spbank_ptr_file #(
        .DATA_W  (DATA_W),
        .ALIGN_W (ALIGN_W),
        .MSP_RST (MSP_RST),
        .PSP_RST (PSP_RST)
    ) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_code),
        .wr_data_i (wr_data),
        .use_psp_i (use_psp),
        .msp_o     (msp),
        .psp_o     (psp)
    );

    assign sp_o       = use_psp ? psp : msp;
    assign active_psp = use_psp;

    always_comb begin
        unique case (rd_code)
            SEL_ALIAS: rd_data = sp_o;
            SEL_MAIN:  rd_data = msp;
            SEL_PROC:  rd_data = psp;
            default:   rd_data = '0;
        endcase
    end

    // R2: the alias read port agrees with the sp_o view.
    a_r2_alias_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code == SEL_ALIAS) |-> (rd_data == sp_o));

    // R11: the unused code reads as zero.
    a_r11_none_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code == SEL_NONE) |-> (rd_data == '0));

endmodule

// File: tb/sim_sp_bank_unit.sv
`timescale 1ns/1ps
module sim_sp_bank_unit;

    localparam logic [31:0] MSP_INIT = 32'h2000_1000;
    localparam logic [31:0] MK_H  = 32'hFFFF_FFF1;
    localparam logic [31:0] MK_TM = 32'hFFFF_FFF9;
    localparam logic [31:0] MK_TP = 32'hFFFF_FFFD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        ctrl_wr_en = 1'b0;
    logic        ctrl_wr_spsel = 1'b0;
    logic        exc_entry = 1'b0;
    logic        exc_exit = 1'b0;
    logic [31:0] exc_ret_val = '0;
    logic [31:0] sp_o;
    logic        active_psp;
    logic [31:0] lr_marker;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sp_bank_unit #(.DATA_W(32), .ALIGN_W(2), .MSP_RST(MSP_INIT), .PSP_RST(32'h0)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_spsel(ctrl_wr_spsel),
        .exc_entry(exc_entry), .exc_exit(exc_exit), .exc_ret_val(exc_ret_val),
        .sp_o(sp_o), .active_psp(active_psp), .lr_marker(lr_marker)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        ent;
        logic        ext;
        logic [31:0] ret;
        logic        cwe;
        logic        cv;
        logic        we;
        logic [1:0]  wsel;
        logic [31:0] wdata;
        logic [1:0]  rsel;
        logic [31:0] exp_rd;
        logic        exp_psp;
        logic [31:0] exp_mk;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        // req ent ext ret  cwe cv we wsel wdata rsel exp_rd exp_psp exp_mk
        '{8'd4,  1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,2'd0,32'h2000_0F03, 2'd0,32'h2000_0F00, 1'b0, 32'h0}, // R4 R2 alias write to main
        '{8'd3,  1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,2'd2,32'h2000_0807, 2'd2,32'h2000_0804, 1'b0, 32'h0}, // R3 direct process write
        '{8'd2,  1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0F00, 1'b0, 32'h0}, // R2 alias reads main
        '{8'd5,  1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0804, 1'b1, 32'h0}, // R5 select process
        '{8'd2,  1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,2'd0,32'h2000_0700, 2'd2,32'h2000_0700, 1'b1, 32'h0}, // R2 alias write to process
        '{8'd3,  1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,2'd1,32'h2000_0E00, 2'd1,32'h2000_0E00, 1'b1, 32'h0}, // R3 main write while process active
        '{8'd6,  1'b1,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R6 entry from thread process
        '{8'd7,  1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R7 control write ignored
        '{8'd6,  1'b1,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_H},  // R6 nested entry
        '{8'd9,  1'b0,1'b1,32'h1234_5678, 1'b0,1'b0, 1'b0,2'd0,32'h0,  2'd0,32'h2000_0E00, 1'b0, MK_H},  // R9 bad return value
        '{8'd9,  1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_H},  // R9 still handler
        '{8'd8,  1'b0,1'b1,MK_H,  1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_H},  // R8 return to handler
        '{8'd8,  1'b0,1'b1,MK_TP, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0700, 1'b1, MK_H},  // R8 return to thread process
        '{8'd11, 1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b1,2'd3,32'hDEAD_BEEC, 2'd3,32'h0,          1'b1, MK_H},  // R11 unused code
        '{8'd11, 1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd1,32'h2000_0E00, 1'b1, MK_H},  // R11 main untouched
        '{8'd11, 1'b0,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd2,32'h2000_0700, 1'b1, MK_H},  // R11 process untouched
        '{8'd10, 1'b1,1'b1,MK_TP, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R10 entry wins
        '{8'd8,  1'b0,1'b1,MK_TM, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R8 return to thread main
        '{8'd9,  1'b0,1'b1,MK_TP, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R9 exit in thread ignored
        '{8'd5,  1'b0,1'b0,32'h0, 1'b1,1'b1, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0700, 1'b1, MK_TP}, // R5 select process
        '{8'd5,  1'b0,1'b0,32'h0, 1'b1,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TP}, // R5 select main
        '{8'd6,  1'b1,1'b0,32'h0, 1'b0,1'b0, 1'b0,2'd0,32'h0,          2'd0,32'h2000_0E00, 1'b0, MK_TM}  // R6 entry from thread main
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; ctrl_wr_en = 1'b0; exc_entry = 1'b0; exc_exit = 1'b0;
        exc_ret_val = '0; wr_data = '0; wr_sel = 2'd0; ctrl_wr_spsel = 1'b0;
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        string tag;
        // R1: reset state
        #12;
        chk("R1 sp", sp_o, MSP_INIT);
        chk("R1 active", {31'b0, active_psp}, 32'h0);
        chk("R1 marker", lr_marker, 32'h0);
        rd_sel = 2'd2; #1;
        chk("R1 process", rd_data, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            exc_entry = VEC[i].ent; exc_exit = VEC[i].ext; exc_ret_val = VEC[i].ret;
            ctrl_wr_en = VEC[i].cwe; ctrl_wr_spsel = VEC[i].cv;
            wr_en = VEC[i].we; wr_sel = VEC[i].wsel; wr_data = VEC[i].wdata;
            rd_sel = VEC[i].rsel;
            @(posedge clk); #1;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk({tag, " rd"}, rd_data, VEC[i].exp_rd);
            chk({tag, " active"}, {31'b0, active_psp}, {31'b0, VEC[i].exp_psp});
            chk({tag, " marker"}, lr_marker, VEC[i].exp_mk);
        end

        // R8: return to thread process, then R2 alias write together with entry
        @(negedge clk);
        idle_inputs();
        exc_exit = 1'b1; exc_ret_val = MK_TP;
        @(posedge clk); #1;
        chk("R8 process active", {31'b0, active_psp}, 32'h1);
        @(negedge clk);
        idle_inputs();
        exc_entry = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h2000_0601;
        rd_sel = 2'd2;
        @(posedge clk); #1;
        chk("R2 entry write to process", rd_data, 32'h2000_0600);
        rd_sel = 2'd1; #0.5;
        chk("R2 main unchanged", rd_data, 32'h2000_0E00);
        chk("R2 sp_o main", sp_o, 32'h2000_0E00);
        chk("R6 marker process", lr_marker, MK_TP);
        @(negedge clk);
        idle_inputs();

        // R1: second reset
        rst_n = 1'b0; #1;
        rd_sel = 2'd0; #0.5;
        chk("R1 re-reset sp", rd_data, MSP_INIT);
        chk("R1 re-reset active", {31'b0, active_psp}, 32'h0);
        rd_sel = 2'd2; #0.5;
        chk("R1 re-reset process", rd_data, 32'h0);
        chk("R1 re-reset marker", lr_marker, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule